// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Every line carries a tag, one data word and a two-bit coherence state: Invalid, Shared or Modified. A Shared line is clean and may also sit in other caches. A Modified line is the only up-to-date copy anywhere, and main memory holds stale data for it. The processor side holds a request until the controller answers it with a one-cycle completion pulse. While the request waits, a stall flag is raised.

When a request misses, the controller works on the bus by itself. It first asks for the bus and waits for a grant. If the victim line is dirty, it writes the victim back. It then issues a read (for a processor read) or a read-exclusive (for a processor write, including the upgrade of a Shared line). When the fill completes, the controller returns to idle and retries the request, which now hits. At the same time, the controller watches transactions that other caches put on the bus. A snooped read or read-exclusive that matches a Modified line makes the block drive its word onto the bus in the same cycle and then downgrade or drop the line. A snooped read-exclusive also drops a matching Shared line.

Top module: `msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, bus_req and cpu_stall are low, bus_cmd is 00 (no operation) and no snoop produces a flush.
- R2: A processor read to an Invalid line issues one bus read (bus_cmd 01) at the request address. After that transfer the line is Shared and the read completes with the word the bus returned.
- R3: A processor write to an Invalid line issues one bus read-exclusive (bus_cmd 10) at the request address. The write is then applied and the line becomes Modified.
- R4: A processor read to a Shared or Modified line with a matching tag completes in the cycle it is presented, returns the stored word and raises no bus request.
- R5: A processor write to a Shared line issues a bus read-exclusive (bus_cmd 10) at that address before it completes, and leaves the line Modified.
- R6: A processor write to a Modified line completes in the cycle it is presented with no bus request, and the new word replaces the old one.
- R7: A snooped read (snp_cmd 01) matching a Shared line flushes nothing and leaves the line Shared. A snooped read-exclusive (snp_cmd 10) matching a Shared line flushes nothing and makes it Invalid.
- R8: A snooped read or read-exclusive matching a Modified line raises snp_flush with the line's word in the same cycle. The line then becomes Shared after a read and Invalid after a read-exclusive.
- R9: A miss whose victim line is Modified first issues a write-back (bus_cmd 11) carrying the victim's address {victim tag, index} and word. The fill transaction follows, and the victim is Invalid after the write-back.
- R10: A snoop presented in the same cycle as a processor request is served first. The processor request does not complete in that cycle and cpu_stall stays high.
- R11: bus_cmd is 00 whenever bus_gnt is low. Once granted, bus_req stays high until the cycle in which bus_gnt and bus_ack are both high.
- R12: A snoop whose tag does not match the line at its index, or whose command is write-back (11), flushes nothing and leaves the line unchanged.
- R13: A miss whose victim line is Shared or Invalid issues no write-back and goes straight to the fill transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits index the line, high bits form the tag |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Word of the indexed line |
| cpu_done | output | 1 | Request completes this cycle (hit) |
| cpu_stall | output | 1 | Request pending and not completing |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-exclusive, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word, valid with bus_ack |
| bus_ack | input | 1 | Transaction complete when high together with bus_gnt |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Flushed word |

## Verification
Processor accesses are run against every starting state. Reads and writes to Invalid lines tell the read fill apart from the read-exclusive fill. Writes to Shared lines expose the upgrade path. Repeated accesses to Modified lines must produce no bus traffic at all. Snoops of each command reach lines in each state, so the bench can separate a silent snoop, an invalidation and a flush with downgrade; each state change is confirmed by the bus traffic of a later processor access. Same-index conflicts, with dirty and with clean victims, separate write-back-then-fill from a direct fill. A request that arrives together with a snoop shows that the snoop takes priority.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NOP = 2'b00,
    BC_RD  = 2'b01,
    BC_RDX = 2'b10,
    BC_WB  = 2'b11
  } bus_cmd_t;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_WBACK = 2'd1,
    MS_FILL  = 2'd2
  } miss_st_t;

  // A processor access is served locally only if the state already grants it.
  function automatic logic cpu_hits(line_st_t st, logic we);
    if (we) return st == LS_MOD;
    return st != LS_INV;
  endfunction

  function automatic line_st_t fill_state(logic we);
    return we ? LS_MOD : LS_SHR;
  endfunction

  function automatic bus_cmd_t miss_cmd(logic we);
    return we ? BC_RDX : BC_RD;
  endfunction

  function automatic logic snoop_flushes(line_st_t st, bus_cmd_t c);
    return (st == LS_MOD) && (c == BC_RD || c == BC_RDX);
  endfunction

  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_t c);
    case (c)
      BC_RD:   return (st == LS_MOD) ? LS_SHR : st;
      BC_RDX:  return LS_INV;
      default: return st;
    endcase
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAGW  = 13,
  parameter int DW    = 32,
  parameter int IDXW  = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  // read port for the processor side
  input  logic [IDXW-1:0] a_idx,
  output line_st_t        a_st,
  output logic [TAGW-1:0] a_tag,
  output logic [DW-1:0]   a_data,
  // read port for the snoop side
  input  logic [IDXW-1:0] b_idx,
  output line_st_t        b_st,
  output logic [TAGW-1:0] b_tag,
  output logic [DW-1:0]   b_data,
  // whole-line fill
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [TAGW-1:0] fill_tag,
  input  line_st_t        fill_st,
  input  logic [DW-1:0]   fill_data,
  // state-only update
  input  logic            st_we,
  input  logic [IDXW-1:0] st_idx,
  input  line_st_t        st_val,
  // data-only update
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data
);

  line_st_t        st_v  [LINES];
  logic [TAGW-1:0] tag_v [LINES];
  logic [DW-1:0]   dat_v [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_t        st_q;
    logic [TAGW-1:0] tag_q;
    logic [DW-1:0]   dat_q;
    logic            sel_fill, sel_st, sel_wr;

    assign sel_fill = fill_en && (fill_idx == IDXW'(i));
    assign sel_st   = st_we   && (st_idx   == IDXW'(i));
    assign sel_wr   = wr_en   && (wr_idx   == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_INV;
        tag_q <= '0;
        dat_q <= '0;
      end else if (sel_fill) begin
        st_q  <= fill_st;
        tag_q <= fill_tag;
        dat_q <= fill_data;
      end else begin
        if (sel_st) st_q  <= st_val;
        if (sel_wr) dat_q <= wr_data;
      end
    end

    assign st_v[i]  = st_q;
    assign tag_v[i] = tag_q;
    assign dat_v[i] = dat_q;
  end

  assign a_st   = st_v[a_idx];
  assign a_tag  = tag_v[a_idx];
  assign a_data = dat_v[a_idx];
  assign b_st   = st_v[b_idx];
  assign b_tag  = tag_v[b_idx];
  assign b_data = dat_v[b_idx];

endmodule

// File: rtl/msi_snoop.sv
module msi_snoop
  import msi_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int IDXW = 3,
  parameter int TAGW = AW - IDXW
) (
  input  logic            snp_valid,
  input  logic [1:0]      snp_cmd,
  input  logic [AW-1:0]   snp_addr,
  output logic [IDXW-1:0] look_idx,
  input  line_st_t        line_st,
  input  logic [TAGW-1:0] line_tag,
  input  logic [DW-1:0]   line_data,
  output logic            flush,
  output logic [DW-1:0]   flush_data,
  output logic            upd_en,
  output line_st_t        upd_st,
  output logic            ev_inv
);

  bus_cmd_t cmd;
  logic     match;
  line_st_t nxt;

  assign cmd      = bus_cmd_t'(snp_cmd);
  assign look_idx = snp_addr[IDXW-1:0];
  assign match    = snp_valid && (line_st != LS_INV) &&
                    (line_tag == snp_addr[AW-1:IDXW]);
  assign nxt      = snoop_next(line_st, cmd);

  assign flush      = match && snoop_flushes(line_st, cmd);
  assign flush_data = flush ? line_data : '0;
  assign upd_en     = match && (nxt != line_st);
  assign upd_st     = nxt;
  assign ev_inv     = upd_en && (nxt == LS_INV);

endmodule

// File: rtl/msi_miss_fsm.sv
module msi_miss_fsm
  import msi_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int IDXW = 3,
  parameter int TAGW = AW - IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            snp_valid,
  input  line_st_t        line_st,
  input  logic [TAGW-1:0] line_tag,
  input  logic [DW-1:0]   line_data,
  input  logic            bus_gnt,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_req,
  output logic [1:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            wr_en,
  output logic [DW-1:0]   wr_data,
  output logic            fill_en,
  output logic [TAGW-1:0] fill_tag,
  output line_st_t        fill_st,
  output logic [DW-1:0]   fill_data,
  output logic            inval_en,
  output logic            ev_hit,
  output logic            ev_miss,
  output logic            ev_wb_done,
  output logic            ev_fill_done
);

  miss_st_t        st_q, st_d;
  logic [IDXW-1:0] req_idx;
  logic [TAGW-1:0] req_tag;
  logic            line_hit, victim_dirty, xfer, idle_ok;

  assign req_idx      = cpu_addr[IDXW-1:0];
  assign req_tag      = cpu_addr[AW-1:IDXW];
  assign line_hit     = (line_st != LS_INV) && (line_tag == req_tag) &&
                        cpu_hits(line_st, cpu_we);
  assign victim_dirty = (line_st == LS_MOD) && (line_tag != req_tag);
  assign xfer         = bus_gnt && bus_ack;
  // snoops own the cycle; the processor waits
  assign idle_ok      = (st_q == MS_IDLE) && cpu_req && !snp_valid;

  assign ev_hit       = idle_ok && line_hit;
  assign ev_miss      = idle_ok && !line_hit;
  assign ev_wb_done   = (st_q == MS_WBACK) && victim_dirty && xfer;
  assign ev_fill_done = (st_q == MS_FILL) && xfer;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MS_IDLE:  if (ev_miss) st_d = victim_dirty ? MS_WBACK : MS_FILL;
      // a snoop may have taken the victim away while waiting for the grant
      MS_WBACK: if (!victim_dirty || xfer) st_d = MS_FILL;
      MS_FILL:  if (xfer) st_d = MS_IDLE;
      default:  st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MS_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    bus_req   = (st_q == MS_FILL) || ((st_q == MS_WBACK) && victim_dirty);
    bus_cmd   = BC_NOP;
    bus_addr  = '0;
    bus_wdata = '0;
    if (bus_req) begin
      if (st_q == MS_WBACK) begin
        bus_addr  = {line_tag, req_idx};
        bus_wdata = line_data;
      end else begin
        bus_addr  = cpu_addr;
      end
      if (bus_gnt) bus_cmd = (st_q == MS_WBACK) ? BC_WB : miss_cmd(cpu_we);
    end
  end

  assign wr_en     = ev_hit && cpu_we;
  assign wr_data   = cpu_wdata;
  assign fill_en   = ev_fill_done;
  assign fill_tag  = req_tag;
  assign fill_st   = fill_state(cpu_we);
  assign fill_data = bus_rdata;
  assign inval_en  = ev_wb_done;

endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = ADDR_W - IDXW;

  line_st_t        a_st, b_st, fill_st, snp_st, st_val;
  logic [TAGW-1:0] a_tag, b_tag, fill_tag;
  logic [DATA_W-1:0] a_data, b_data, fill_data, wr_data;
  logic [IDXW-1:0] req_idx, snp_idx, st_idx;
  logic            fill_en, wr_en, inval_en, snp_upd, st_we;

  // named internal events for the checker
  logic ev_hit, ev_miss, ev_wb_done, ev_fill_done, ev_snp_inv;

  assign req_idx = cpu_addr[IDXW-1:0];

  msi_line_store #(
    .LINES(LINES), .TAGW(TAGW), .DW(DATA_W), .IDXW(IDXW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (req_idx),
    .a_st     (a_st),
    .a_tag    (a_tag),
    .a_data   (a_data),
    .b_idx    (snp_idx),
    .b_st     (b_st),
    .b_tag    (b_tag),
    .b_data   (b_data),
    .fill_en  (fill_en),
    .fill_idx (req_idx),
    .fill_tag (fill_tag),
    .fill_st  (fill_st),
    .fill_data(fill_data),
    .st_we    (st_we),
    .st_idx   (st_idx),
    .st_val   (st_val),
    .wr_en    (wr_en),
    .wr_idx   (req_idx),
    .wr_data  (wr_data)
  );

  msi_snoop #(
    .AW(ADDR_W), .DW(DATA_W), .IDXW(IDXW), .TAGW(TAGW)
  ) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .look_idx  (snp_idx),
    .line_st   (b_st),
    .line_tag  (b_tag),
    .line_data (b_data),
    .flush     (snp_flush),
    .flush_data(snp_data),
    .upd_en    (snp_upd),
    .upd_st    (snp_st),
    .ev_inv    (ev_snp_inv)
  );

  msi_miss_fsm #(
    .AW(ADDR_W), .DW(DATA_W), .IDXW(IDXW), .TAGW(TAGW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .snp_valid   (snp_valid),
    .line_st     (a_st),
    .line_tag    (a_tag),
    .line_data   (a_data),
    .bus_gnt     (bus_gnt),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .fill_en     (fill_en),
    .fill_tag    (fill_tag),
    .fill_st     (fill_st),
    .fill_data   (fill_data),
    .inval_en    (inval_en),
    .ev_hit      (ev_hit),
    .ev_miss     (ev_miss),
    .ev_wb_done  (ev_wb_done),
    .ev_fill_done(ev_fill_done)
  );

  // snoop updates win the state write port
  assign st_we  = snp_upd || inval_en;
  assign st_idx = snp_upd ? snp_idx : req_idx;
  assign st_val = snp_upd ? snp_st  : LS_INV;

  assign cpu_rdata = a_data;
  assign cpu_done  = ev_hit;
  assign cpu_stall = cpu_req && !ev_hit;

endmodule

// File: rtl/msi_ctrl_sva.sv
module msi_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_ack,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_flush,
  input logic       ev_wb_done,
  input logic       ev_fill_done,
  input logic       ev_snp_inv
);

  // R11: commands only under grant
  a_r11_cmd_granted: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd != 2'b00 |-> bus_gnt);

  // R11: a granted request is held until acknowledged
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_ack |=> bus_req);

  // R10: snoops take the cycle
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done);

  // R4: hits make no bus request
  a_r4_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req);

  // R8: flush only in answer to a snooped read or read-exclusive
  a_r8_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10));

  // R9: the fill follows a finished write-back
  a_r9_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> bus_req);

  // R2: after a fill the controller is back at idle
  a_r2_idle_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> !bus_req);

  // R12: snooped write-backs are ignored
  a_r12_wb_snoop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == 2'b11 |-> !snp_flush && !ev_snp_inv);

endmodule

bind msi_ctrl msi_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_done    (cpu_done),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_ack     (bus_ack),
  .bus_cmd     (bus_cmd),
  .snp_valid   (snp_valid),
  .snp_cmd     (snp_cmd),
  .snp_flush   (snp_flush),
  .ev_wb_done  (ev_wb_done),
  .ev_fill_done(ev_fill_done),
  .ev_snp_inv  (ev_snp_inv)
);

// File: tb/tb_msi_ctrl.sv
module tb_msi_ctrl;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_done, cpu_stall;
  logic          bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush;
  logic [DW-1:0] snp_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  msi_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  // memory model
  logic [DW-1:0] mem [int unsigned];

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h5A00_0000 | {16'h0, a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // scoreboard of expected bus transactions
  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         rq;
  } exp_t;
  exp_t q[$];

  task automatic expect_bus(input logic [1:0] c, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string rq);
    exp_t e;
    e.cmd = c; e.addr = a; e.data = d; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic monitor_xfer();
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R11", "unexpected transaction cmd", {30'h0, bus_cmd}, 32'h0);
    end else begin
      e = q.pop_front();
      check(bus_cmd == e.cmd, e.rq, "bus cmd", {30'h0, bus_cmd}, {30'h0, e.cmd});
      check(bus_addr == e.addr, e.rq, "bus addr", {16'h0, bus_addr}, {16'h0, e.addr});
      if (e.cmd == 2'b11)
        check(bus_wdata == e.data, e.rq, "write-back data", bus_wdata, e.data);
    end
    if (bus_cmd == 2'b11) mem[int'(bus_addr)] = bus_wdata;
  endtask

  // bus responder and monitor: grant, then acknowledge one cycle later
  int phase = 0;
  always @(negedge clk) begin
    if (!rst_n || !bus_req) begin
      if (rst_n && bus_cmd != 2'b00)
        check(1'b0, "R11", "command without request", {30'h0, bus_cmd}, 32'h0);
      bus_gnt = 1'b0; bus_ack = 1'b0; phase = 0;
    end else begin
      case (phase)
        0: begin
          if (bus_cmd != 2'b00)
            check(1'b0, "R11", "command before grant", {30'h0, bus_cmd}, 32'h0);
          bus_gnt = 1'b1; phase = 1;
        end
        1: begin
          bus_ack = 1'b1;
          bus_rdata = mem_rd(bus_addr);
          phase = 2;
          #1 monitor_xfer();
        end
        default: begin
          bus_gnt = 1'b0; bus_ack = 1'b0; phase = 0;
        end
      endcase
    end
  end

  // driver: one processor access; called at a falling edge
  task automatic cpu_op(input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] exp_rd,
                        input bit exp_now, input string rq);
    int cyc;
    cyc = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (!cpu_done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      #1;
    end
    check(cpu_done, rq, "completion", {31'h0, cpu_done}, 32'h1);
    if (exp_now) check(cyc == 0, rq, "hit latency", cyc, 0);
    else         check(cyc > 0,  rq, "miss latency", cyc, 1);
    if (!we) check(cpu_rdata == exp_rd, rq, "read data", cpu_rdata, exp_rd);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    check(q.size() == 0, rq, "pending bus transactions", q.size(), 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       input bit exp_fl, input logic [DW-1:0] exp_d, input string rq);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    check(snp_flush == exp_fl, rq, "flush", {31'h0, snp_flush}, {31'h0, exp_fl});
    if (exp_fl) begin
      check(snp_data == exp_d, rq, "flush data", snp_data, exp_d);
      mem[int'(a)] = snp_data;
    end
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'b00; snp_addr = '0;
  endtask

  localparam logic [DW-1:0] VA = 32'hA0A0_0011;
  localparam logic [DW-1:0] VB = 32'hB0B0_0011;
  localparam logic [DW-1:0] VC = 32'hC0C0_0022;
  localparam logic [DW-1:0] VD = 32'hD0D0_0033;
  localparam logic [DW-1:0] VE = 32'hE0E0_0044;
  localparam logic [DW-1:0] VF = 32'hF0F0_0054;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(bus_req == 1'b0, "R1", "bus_req", {31'h0, bus_req}, 32'h0);
    check(cpu_stall == 1'b0, "R1", "cpu_stall", {31'h0, cpu_stall}, 32'h0);
    check(bus_cmd == 2'b00, "R1", "bus_cmd", {30'h0, bus_cmd}, 32'h0);
    snoop(2'b01, 16'h0010, 1'b0, '0, "R1");

    // R2 read miss on Invalid
    expect_bus(2'b01, 16'h0011, '0, "R2");
    cpu_op(1'b0, 16'h0011, '0, 32'h5A00_0011, 1'b0, "R2");
    // R4 read hit on Shared
    cpu_op(1'b0, 16'h0011, '0, 32'h5A00_0011, 1'b1, "R4");
    // R7 snoop read on Shared: silent, still Shared
    snoop(2'b01, 16'h0011, 1'b0, '0, "R7");
    cpu_op(1'b0, 16'h0011, '0, 32'h5A00_0011, 1'b1, "R7");

    // R5 upgrade write on Shared
    expect_bus(2'b10, 16'h0011, '0, "R5");
    cpu_op(1'b1, 16'h0011, VA, '0, 1'b0, "R5");
    cpu_op(1'b0, 16'h0011, '0, VA, 1'b1, "R4");
    // R6 write hit on Modified
    cpu_op(1'b1, 16'h0011, VB, '0, 1'b1, "R6");
    cpu_op(1'b0, 16'h0011, '0, VB, 1'b1, "R6");

    // R8 snoop read on Modified: flush, then Shared
    snoop(2'b01, 16'h0011, 1'b1, VB, "R8");
    snoop(2'b01, 16'h0011, 1'b0, '0, "R8");
    cpu_op(1'b0, 16'h0011, '0, VB, 1'b1, "R8");
    // R7 snoop read-exclusive on Shared: Invalid
    snoop(2'b10, 16'h0011, 1'b0, '0, "R7");
    expect_bus(2'b01, 16'h0011, '0, "R7");
    cpu_op(1'b0, 16'h0011, '0, VB, 1'b0, "R7");

    // R3 write miss on Invalid
    expect_bus(2'b10, 16'h0022, '0, "R3");
    cpu_op(1'b1, 16'h0022, VC, '0, 1'b0, "R3");
    // R12 ignored snoops
    snoop(2'b11, 16'h0022, 1'b0, '0, "R12");
    snoop(2'b01, 16'h0032, 1'b0, '0, "R12");
    snoop(2'b10, 16'h0032, 1'b0, '0, "R12");
    cpu_op(1'b0, 16'h0022, '0, VC, 1'b1, "R12");
    cpu_op(1'b1, 16'h0022, VC, '0, 1'b1, "R3");
    // R8 snoop read-exclusive on Modified: flush, then Invalid
    snoop(2'b10, 16'h0022, 1'b1, VC, "R8");
    expect_bus(2'b01, 16'h0022, '0, "R8");
    cpu_op(1'b0, 16'h0022, '0, VC, 1'b0, "R8");

    // R9 dirty victim written back before the fill
    expect_bus(2'b10, 16'h0033, '0, "R3");
    cpu_op(1'b1, 16'h0033, VD, '0, 1'b0, "R3");
    expect_bus(2'b11, 16'h0033, VD, "R9");
    expect_bus(2'b01, 16'h0043, '0, "R9");
    cpu_op(1'b0, 16'h0043, '0, 32'h5A00_0043, 1'b0, "R9");
    // R13 clean victim replaced without write-back
    expect_bus(2'b01, 16'h0033, '0, "R13");
    cpu_op(1'b0, 16'h0033, '0, VD, 1'b0, "R13");

    // R10 snoop and processor request in the same cycle
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0033;
    snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = 16'h0071;
    #1;
    check(cpu_done == 1'b0, "R10", "done during snoop", {31'h0, cpu_done}, 32'h0);
    check(cpu_stall == 1'b1, "R10", "stall during snoop", {31'h0, cpu_stall}, 32'h1);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'b00; snp_addr = '0;
    #1;
    check(cpu_done == 1'b1, "R10", "done after snoop", {31'h0, cpu_done}, 32'h1);
    check(cpu_rdata == VD, "R10", "read data", cpu_rdata, VD);
    @(negedge clk);
    cpu_req = 1'b0;

    // R9 write miss with dirty victim: write-back then read-exclusive
    expect_bus(2'b10, 16'h0044, '0, "R3");
    cpu_op(1'b1, 16'h0044, VE, '0, 1'b0, "R3");
    expect_bus(2'b11, 16'h0044, VE, "R9");
    expect_bus(2'b10, 16'h0054, '0, "R9");
    cpu_op(1'b1, 16'h0054, VF, '0, 1'b0, "R9");
    snoop(2'b01, 16'h0044, 1'b0, '0, "R9");
    snoop(2'b01, 16'h0054, 1'b1, VF, "R8");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule